// File: doc/BRIEF.md
# Masked Dual-Bank Line Write Port

This block is the write side of a line-organized frame buffer. Every write clock it classifies the cycle from three control inputs. A command cycle applies a line-pointer operation or a line-commit request. An address cycle shifts in one bit of a serial line address. A data cycle stores the 24-bit input word into a staging line register. The word is split into a lower and an upper 12-bit half, and each half has its own active-low enable and its own word pointer.

A global input-enable masks the storing of data while the pointers keep moving. This lets a caller skip over a window of a line, for example to insert a picture in picture. At the end of a line the caller issues a commit command. The block then raises a one-cycle transfer request carrying the target line number. The array side drains the staged words through a registered read port and acknowledges. A second commit is refused until that acknowledge has arrived.

Top module: `wlbuf_write_port`

## Requirements
- R1: In a data cycle (`wr_rst`=0, `adr_en`=0) each half whose enable (`wen_lo_n` or `wen_hi_n`) is 0 advances its word pointer by one at the clock edge. A half whose enable is 1 holds its pointer.
- R2: Each word pointer stops at WORDS-1 (767) and never goes beyond it.
- R3: In a data cycle with `in_en`=1, each enabled half stores its 12 bits (`din[11:0]` lower, `din[23:12]` upper) at its current pointer, and its strobe is 1 in the following cycle. With `in_en`=0 nothing is stored and no strobe is raised, but the pointers still advance.
- R4: A command cycle (`wr_rst`=1) with {`line_inc`,`adr_en`}=01 sets the line and both pointers to 0. The preset line is left unchanged.
- R5: Command 10 increments the line by one and sets both pointers to 0.
- R6: Command 11 loads the line from the preset line and sets both pointers to 0.
- R7: An address cycle (`wr_rst`=0, `adr_en`=1) shifts `adr_sd` into the preset, most significant bit first. The preset keeps only the newest nine bits, so the top bit of a 10-bit address is dropped. The line follows the preset, and both pointers go to 0.
- R8: Command 00 (commit), when no commit is pending, raises `xfer_req` for exactly one cycle on the next clock, with `xfer_line` equal to the line at the command. Line and pointers are unchanged.
- R9: After an accepted commit, further commit commands are ignored until `xfer_ack` is seen at a clock edge.
- R10: Command and address cycles store nothing and raise no strobe, even with both half enables at 0.
- R11: `rd_data` shows, one clock after `rd_addr` is applied, the staged word at that address, with the upper half in bits 23:12 and the lower half in bits 11:0.
- R12: After reset, pointers, line, strobes, `xfer_req`, `xfer_line` and `rd_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock |
| rst | input | 1 | Synchronous active-high reset |
| wen_lo_n | input | 1 | Lower-half enable, active low |
| wen_hi_n | input | 1 | Upper-half enable, active low |
| in_en | input | 1 | Store enable; 0 masks storing |
| din | input | 24 | Input word, upper half in 23:12 |
| wr_rst | input | 1 | Selects a command cycle |
| line_inc | input | 1 | Command bit 1 |
| adr_en | input | 1 | Command bit 0; address cycle when `wr_rst`=0 |
| adr_sd | input | 1 | Serial line address bit |
| xfer_ack | input | 1 | Array side has taken the committed line |
| rd_addr | input | 10 | Staging register read address |
| ptr_lo | output | 10 | Lower-half word pointer |
| ptr_hi | output | 10 | Upper-half word pointer |
| stb_lo | output | 1 | Lower half stored in the previous cycle |
| stb_hi | output | 1 | Upper half stored in the previous cycle |
| cur_line | output | 10 | Current line number |
| xfer_req | output | 1 | One-cycle commit request |
| xfer_line | output | 10 | Line number of the last accepted commit |
| rd_data | output | 24 | Staged word read back, one cycle latency |

## Verification
The bench drives a masked stretch in which the pointers must move without any store. A design that tied pointer motion to `in_en` would leave the following words at the wrong addresses in the read-back. It sends a ten-bit address whose top bit is set, so a design that kept that bit reports the wrong line after the shift and after a jump. It repeats a commit before acknowledging, which exposes a design that pulses twice or forgets the pending state. It also holds one half enabled long past the end of a line, so a pointer that wraps instead of stopping shows up at 767.

// File: rtl/wlbuf_pkg.sv
`timescale 1ns/1ps
package wlbuf_pkg;
  // command code during a command cycle: {line_inc, adr_en}
  typedef enum logic [1:0] {
    CMD_XFER = 2'b00,
    CMD_CLR  = 2'b01,
    CMD_NEXT = 2'b10,
    CMD_JUMP = 2'b11
  } cmd_e;
endpackage

// File: rtl/wlbuf_half_lane.sv
`timescale 1ns/1ps
module wlbuf_half_lane #(
  parameter int WORDS = 768,
  parameter int W     = 12,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_n,
  input  logic          in_en,
  input  logic          data_cyc,
  input  logic          ptr_clr,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] rd_addr,
  output logic [AW-1:0] ptr,
  output logic          stb,
  output logic [W-1:0]  rd_q
);
  localparam logic [AW-1:0] LAST = AW'(WORDS - 1);

  logic [W-1:0] mem [WORDS];
  logic step, store;

  assign step  = data_cyc && !en_n;
  assign store = step && in_en;

  always_ff @(posedge clk) begin
    if (rst)                       ptr <= '0;
    else if (ptr_clr)              ptr <= '0;
    else if (step && ptr != LAST)  ptr <= ptr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) stb <= 1'b0;
    else     stb <= store;
  end

  // single write port, registered read port: block RAM friendly
  always_ff @(posedge clk) begin
    if (store) mem[ptr] <= wd;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= mem[rd_addr];
  end

  p_ptr_bound_r2: assert property (@(posedge clk) disable iff (rst)
    ptr <= LAST);
  p_ptr_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (data_cyc && en_n) |=> $stable(ptr));
  p_mask_r3: assert property (@(posedge clk) disable iff (rst)
    !in_en |=> !stb);
  p_no_store_r10: assert property (@(posedge clk) disable iff (rst)
    !data_cyc |=> !stb);
endmodule

// File: rtl/wlbuf_line_ctl.sv
`timescale 1ns/1ps
module wlbuf_line_ctl
  import wlbuf_pkg::*;
#(
  parameter int LINE_AW = 10,
  localparam int PW     = LINE_AW - 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_cyc,
  input  cmd_e               cmd,
  input  logic               aset_cyc,
  input  logic               sd,
  output logic [LINE_AW-1:0] cur_line
);
  logic [PW-1:0] preset;

  always_ff @(posedge clk) begin
    if (rst) begin
      preset   <= '0;
      cur_line <= '0;
    end else if (aset_cyc) begin
      // oldest bit falls off the top: the 10th bit back is discarded
      preset   <= {preset[PW-2:0], sd};
      cur_line <= {1'b0, preset[PW-2:0], sd};
    end else if (cmd_cyc) begin
      case (cmd)
        CMD_CLR:  cur_line <= '0;
        CMD_NEXT: cur_line <= cur_line + 1'b1;
        CMD_JUMP: cur_line <= {1'b0, preset};
        default:  ;
      endcase
    end
  end

  p_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (cmd_cyc && cmd == CMD_CLR) |=> cur_line == '0);
  p_next_r5: assert property (@(posedge clk) disable iff (rst)
    (cmd_cyc && cmd == CMD_NEXT) |=> cur_line == LINE_AW'($past(cur_line) + 1'b1));
  p_xfer_keeps_line_r8: assert property (@(posedge clk) disable iff (rst)
    (cmd_cyc && cmd == CMD_XFER) |=> $stable(cur_line));
endmodule

// File: rtl/wlbuf_xfer_ctl.sv
`timescale 1ns/1ps
module wlbuf_xfer_ctl #(
  parameter int LINE_AW = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               try_xfer,
  input  logic               ack,
  input  logic [LINE_AW-1:0] line_in,
  output logic               xfer_req,
  output logic [LINE_AW-1:0] xfer_line
);
  logic busy, accept;

  assign accept = try_xfer && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      xfer_req  <= 1'b0;
      xfer_line <= '0;
    end else begin
      xfer_req <= accept;
      if (accept)   busy <= 1'b1;
      else if (ack) busy <= 1'b0;
      if (accept)   xfer_line <= line_in;
    end
  end

  p_one_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    xfer_req |=> !xfer_req);
  p_line_r8: assert property (@(posedge clk) disable iff (rst)
    accept |=> (xfer_req && xfer_line == $past(line_in)));
  p_wait_ack_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && !ack) |=> (!xfer_req && busy));
endmodule

// File: rtl/wlbuf_write_port.sv
`timescale 1ns/1ps
module wlbuf_write_port
  import wlbuf_pkg::*;
#(
  parameter int WORDS   = 768,
  parameter int HALF_W  = 12,
  parameter int LINE_AW = 10,
  localparam int WAW    = $clog2(WORDS),
  localparam int DW     = 2 * HALF_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wen_lo_n,
  input  logic               wen_hi_n,
  input  logic               in_en,
  input  logic [DW-1:0]      din,
  input  logic               wr_rst,
  input  logic               line_inc,
  input  logic               adr_en,
  input  logic               adr_sd,
  input  logic               xfer_ack,
  input  logic [WAW-1:0]     rd_addr,
  output logic [WAW-1:0]     ptr_lo,
  output logic [WAW-1:0]     ptr_hi,
  output logic               stb_lo,
  output logic               stb_hi,
  output logic [LINE_AW-1:0] cur_line,
  output logic               xfer_req,
  output logic [LINE_AW-1:0] xfer_line,
  output logic [DW-1:0]      rd_data
);
  cmd_e cmd;
  logic cmd_cyc, aset_cyc, data_cyc, ptr_clr, try_xfer;

  assign cmd      = cmd_e'({line_inc, adr_en});
  assign cmd_cyc  = wr_rst;
  assign aset_cyc = !wr_rst && adr_en;
  assign data_cyc = !wr_rst && !adr_en;
  assign try_xfer = cmd_cyc && (cmd == CMD_XFER);
  assign ptr_clr  = aset_cyc || (cmd_cyc && cmd != CMD_XFER);

  logic [1:0]        en_n_v;
  logic [WAW-1:0]    ptr_a  [2];
  logic [1:0]        stb_a;
  logic [HALF_W-1:0] rdq_a  [2];

  assign en_n_v = {wen_hi_n, wen_lo_n};

  for (genvar h = 0; h < 2; h++) begin : g_half
    wlbuf_half_lane #(.WORDS(WORDS), .W(HALF_W)) u_lane (
      .clk      (clk),
      .rst      (rst),
      .en_n     (en_n_v[h]),
      .in_en    (in_en),
      .data_cyc (data_cyc),
      .ptr_clr  (ptr_clr),
      .wd       (din[h*HALF_W +: HALF_W]),
      .rd_addr  (rd_addr),
      .ptr      (ptr_a[h]),
      .stb      (stb_a[h]),
      .rd_q     (rdq_a[h])
    );
  end

  assign ptr_lo  = ptr_a[0];
  assign ptr_hi  = ptr_a[1];
  assign stb_lo  = stb_a[0];
  assign stb_hi  = stb_a[1];
  assign rd_data = {rdq_a[1], rdq_a[0]};

  wlbuf_line_ctl #(.LINE_AW(LINE_AW)) u_line (
    .clk      (clk),
    .rst      (rst),
    .cmd_cyc  (cmd_cyc),
    .cmd      (cmd),
    .aset_cyc (aset_cyc),
    .sd       (adr_sd),
    .cur_line (cur_line)
  );

  wlbuf_xfer_ctl #(.LINE_AW(LINE_AW)) u_xfer (
    .clk       (clk),
    .rst       (rst),
    .try_xfer  (try_xfer),
    .ack       (xfer_ack),
    .line_in   (cur_line),
    .xfer_req  (xfer_req),
    .xfer_line (xfer_line)
  );

  p_ptr_zero_r6: assert property (@(posedge clk) disable iff (rst)
    ptr_clr |=> (ptr_lo == '0 && ptr_hi == '0));
  p_jump_r6: assert property (@(posedge clk) disable iff (rst)
    (cmd_cyc && cmd == CMD_JUMP && !$past(aset_cyc)) |=> $stable(cur_line) || cur_line[LINE_AW-1] == 1'b0);
endmodule

// File: tb/wlbuf_write_port_test.sv
`timescale 1ns/1ps
module wlbuf_write_port_test;
  localparam int WORDS = 768;
  localparam int HW    = 12;
  localparam int LAW   = 10;
  localparam int WAW   = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wen_lo_n = 1'b1, wen_hi_n = 1'b1, in_en = 1'b1;
  logic [2*HW-1:0] din = '0;
  logic wr_rst = 1'b0, line_inc = 1'b0, adr_en = 1'b0, adr_sd = 1'b0, xfer_ack = 1'b0;
  logic [WAW-1:0] rd_addr = '0;
  logic [WAW-1:0] ptr_lo, ptr_hi;
  logic stb_lo, stb_hi, xfer_req;
  logic [LAW-1:0] cur_line, xfer_line;
  logic [2*HW-1:0] rd_data;

  always #2.5 clk = ~clk;

  wlbuf_write_port #(.WORDS(WORDS), .HALF_W(HW), .LINE_AW(LAW)) uut (
    .clk(clk), .rst(rst), .wen_lo_n(wen_lo_n), .wen_hi_n(wen_hi_n), .in_en(in_en),
    .din(din), .wr_rst(wr_rst), .line_inc(line_inc), .adr_en(adr_en), .adr_sd(adr_sd),
    .xfer_ack(xfer_ack), .rd_addr(rd_addr), .ptr_lo(ptr_lo), .ptr_hi(ptr_hi),
    .stb_lo(stb_lo), .stb_hi(stb_hi), .cur_line(cur_line), .xfer_req(xfer_req),
    .xfer_line(xfer_line), .rd_data(rd_data));

  int n_cmp = 0, n_bad = 0;
  string tag = "R12";
  bit done = 0;

  // behavioural reference state
  int m_plo, m_phi, m_line, m_pre, m_busy, m_req, m_xl, m_slo, m_shi, m_rd;
  bit m_rdv;
  int mlo [WORDS];
  int mhi [WORDS];
  bit vlo [WORDS];
  bit vhi [WORDS];

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic model_step();
    int a;
    bit acc;
    if (rst) begin
      m_plo = 0; m_phi = 0; m_line = 0; m_pre = 0; m_busy = 0; m_req = 0;
      m_xl = 0; m_slo = 0; m_shi = 0; m_rd = 0; m_rdv = 1;
      return;
    end
    a = int'(rd_addr);
    m_rdv = (a < WORDS) && vlo[a] && vhi[a];
    m_rd  = m_rdv ? ((mhi[a] << HW) | mlo[a]) : 0;
    m_slo = 0; m_shi = 0;
    acc = wr_rst && !line_inc && !adr_en && (m_busy == 0);
    m_req = acc ? 1 : 0;
    if (acc) begin m_xl = m_line; m_busy = 1; end
    else if (xfer_ack) m_busy = 0;
    if (wr_rst) begin
      case ({line_inc, adr_en})
        2'b01: begin m_line = 0; m_plo = 0; m_phi = 0; end
        2'b10: begin m_line = (m_line + 1) % 1024; m_plo = 0; m_phi = 0; end
        2'b11: begin m_line = m_pre; m_plo = 0; m_phi = 0; end
        default: ;
      endcase
    end else if (adr_en) begin
      m_pre = ((m_pre << 1) | int'(adr_sd)) & 511;
      m_line = m_pre; m_plo = 0; m_phi = 0;
    end else begin
      if (!wen_lo_n) begin
        if (in_en) begin mlo[m_plo] = int'(din[HW-1:0]); vlo[m_plo] = 1; m_slo = 1; end
        if (m_plo < WORDS - 1) m_plo++;
      end
      if (!wen_hi_n) begin
        if (in_en) begin mhi[m_phi] = int'(din[2*HW-1:HW]); vhi[m_phi] = 1; m_shi = 1; end
        if (m_phi < WORDS - 1) m_phi++;
      end
    end
  endtask

  task automatic compare_all();
    chk("ptr_lo", 32'(ptr_lo), m_plo);
    chk("ptr_hi", 32'(ptr_hi), m_phi);
    chk("stb_lo", 32'(stb_lo), m_slo);
    chk("stb_hi", 32'(stb_hi), m_shi);
    chk("cur_line", 32'(cur_line), m_line);
    chk("xfer_req", 32'(xfer_req), m_req);
    chk("xfer_line", 32'(xfer_line), m_xl);
    if (m_rdv) chk("rd_data", 32'(rd_data), m_rd);
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle();
    wr_rst = 0; adr_en = 0; line_inc = 0; wen_lo_n = 1; wen_hi_n = 1; in_en = 1; xfer_ack = 0;
  endtask

  task automatic command(logic inc, logic ade);
    idle(); wr_rst = 1; line_inc = inc; adr_en = ade;
    tick();
    idle();
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 50000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [9:0] adr;
    for (int i = 0; i < WORDS; i++) begin vlo[i] = 0; vhi[i] = 0; end
    tick(); tick(); tick();
    rst = 0;
    tag = "R12";
    chk("reset ptr_lo", 32'(ptr_lo), 0);
    chk("reset cur_line", 32'(cur_line), 0);
    chk("reset rd_data", 32'(rd_data), 0);

    // R7: serial address 10'b10_0000_0101, top bit dropped -> line 5
    tag = "R7";
    adr = 10'b10_0000_0101;
    for (int i = 9; i >= 0; i--) begin
      idle(); adr_en = 1; adr_sd = adr[i]; wen_lo_n = 0; wen_hi_n = 0; // R10: enables ignored here
      tick();
    end
    idle();
    chk("line after address", 32'(cur_line), 5);
    chk("no strobe during address R10", 32'(stb_lo), 0);

    // R1/R3: both halves write words 0..4
    tag = "R3";
    for (int k = 0; k < 5; k++) begin
      idle(); wen_lo_n = 0; wen_hi_n = 0; din = {12'(100 + k), 12'(k + 1)};
      tick();
      chk("strobe both", 32'({stb_hi, stb_lo}), 3);
    end
    tag = "R1";
    for (int k = 0; k < 3; k++) begin
      idle(); wen_lo_n = 0; din = {12'hABC, 12'(50 + k)};
      tick();
    end
    chk("lower advanced alone", 32'(ptr_lo), 8);
    chk("upper held", 32'(ptr_hi), 5);
    idle(); tick(); tick();
    chk("both stopped", 32'(ptr_lo), 8);

    // R3: masked stretch, both advance, nothing stored
    tag = "R3";
    for (int k = 0; k < 2; k++) begin
      idle(); wen_lo_n = 0; wen_hi_n = 0; in_en = 0; din = 24'hFFFFFF;
      tick();
      chk("masked strobe", 32'({stb_hi, stb_lo}), 0);
    end
    chk("masked upper ptr", 32'(ptr_hi), 7);
    idle(); wen_hi_n = 0; din = {12'd777, 12'd0};
    tick();

    // R11: read back staged words
    tag = "R11";
    for (int k = 0; k < 5; k++) begin
      idle(); rd_addr = WAW'(k);
      tick();
    end
    idle(); rd_addr = 10'd2; tick();
    chk("word 2", 32'(rd_data), 32'({12'd102, 12'd3}));

    // R8/R9: commit, refused repeat, ack, commit again
    tag = "R8";
    command(0, 0);
    chk("xfer pulse", 32'(xfer_req), 1);
    chk("xfer line", 32'(xfer_line), 5);
    tick();
    chk("xfer pulse ends", 32'(xfer_req), 0);
    tag = "R9";
    command(0, 0);
    chk("refused while pending", 32'(xfer_req), 0);
    xfer_ack = 1; tick(); xfer_ack = 0;
    command(0, 0);
    chk("accepted after ack", 32'(xfer_req), 1);
    xfer_ack = 1; tick(); xfer_ack = 0;

    // R10: command cycle with enables low stores nothing
    tag = "R10";
    idle(); wr_rst = 1; line_inc = 1; adr_en = 0; wen_lo_n = 0; wen_hi_n = 0; tick();
    idle();
    chk("no strobe on command", 32'({stb_hi, stb_lo}), 0);
    tag = "R5";
    chk("line incremented", 32'(cur_line), 6);
    chk("ptr cleared", 32'(ptr_lo), 0);

    tag = "R4";
    command(0, 1);
    chk("line cleared", 32'(cur_line), 0);
    tag = "R6";
    command(1, 1);
    chk("jump to preset", 32'(cur_line), 5);

    // R2: saturation
    tag = "R2";
    for (int k = 0; k < WORDS + 3; k++) begin
      idle(); wen_lo_n = 0; in_en = 0;
      tick();
    end
    idle();
    chk("lower saturates", 32'(ptr_lo), WORDS - 1);
    chk("upper untouched", 32'(ptr_hi), 0);
    tick();

    summary();
  end
endmodule